// File: doc/BRIEF.md
# Receive Word FIFO with Fill-Level Status

This block sits between a serial receive shifter and a small register interface. The shifter hands it one byte at a time with a valid strobe, and pulses an end-of-transfer input after the last byte of a transfer. The block stores up to 64 bytes. Software takes them out one 32-bit word per read of a data register. The oldest byte sits in the least significant byte lane.

A status register reports the number of bytes held, an empty flag, a ready flag, and three fill flags at a quarter, a half and all of the capacity. Writing a one to bit 0 of a flush register discards everything held. Once a transfer has ended, a trailing group of one to three bytes can be read as a partial word. Its valid bytes are packed from bit 0 upward and the unused lanes read as zero. Three interrupt source lines give the ready level, the not-empty level and a one-cycle underrun pulse.

Register offsets on `reg_addr`: 0 is the status register, 1 is the data register (a read pops), 2 is the flush register. Reads return combinationally the register that `reg_addr` selects; a pop, flush or underrun takes effect at the clock edge on which the access is made.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the status word is 0x0000_0800 (empty, count zero, all flags clear) and `int_src` is 0.
- R2: A data read returns the oldest held byte in bits 7:0, and byte i of the word in bits 8i+7:8i, in arrival order.
- R3: Status bits 10:4 hold the number of bytes held. An accepted byte adds one. A data read removes min(count, 4) bytes.
- R4: Status bit 1 is set when at least 16 bytes are held, bit 2 when at least 32 are held, and bit 3 when 64 are held.
- R5: Status bit 0 (ready) is set when at least 4 bytes are held, or when an end-of-transfer has been seen and at least one byte is held.
- R6: A read that finds fewer than 4 bytes returns only those bytes from bit 0 upward, with zero in the unused lanes. The seen-end condition clears when a read empties the store, unless an end-of-transfer arrives in that same cycle.
- R7: Status bit 11 is set exactly when no byte is held, and `int_src[1]` is its inverse.
- R8: A data read with nothing held returns 0 and leaves the count unchanged. `int_src[0]` is high in the following cycle only.
- R9: A register write to offset 2 with bit 0 set empties the store and clears the seen-end condition; a byte arriving in that cycle is dropped. A write there with bit 0 clear changes nothing.
- R10: A byte arriving while 64 are held is dropped, even when a read occurs in the same cycle. The count and the held bytes stay as they were.
- R11: `int_src[2]` always equals status bit 0.
- R12: A byte arrival and a data read in the same cycle both take effect. The read sees only bytes held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte_vld | input | 1 | Byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| rx_xfer_end | input | 1 | End-of-transfer pulse |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| int_src | output | 3 | Bit 0 underrun pulse, bit 1 not empty, bit 2 ready |

## Verification
The hardest case to reach from the ports is the full boundary with a byte arriving while a read pops in the same cycle. There the arriving byte must still be dropped. The stimulus fills the store to exactly 64 bytes, then issues a data read together with a byte strobe. Later cycles check the count and the popped contents.

The other hard case is a transfer that ends on a partial word, followed by new bytes after the drain. Directed sequences cover both cases before a long mixed run of random pushes, pops, end pulses and rare flushes. A queue-based model is compared against the design on every cycle of that run.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RA_STAT  = 0;
  localparam int unsigned RA_DATA  = 1;
  localparam int unsigned RA_FLUSH = 2;

  // bytes one pop removes
  function automatic int unsigned take_bytes(input int unsigned held, input int unsigned lanes);
    return (held < lanes) ? held : lanes;
  endfunction

  // status layout: ready, quarter, half, full, count, empty
  function automatic logic [31:0] status_word(input int unsigned cnt, input int unsigned depth,
                                              input int unsigned cw, input logic ready);
    logic [31:0] s;
    s = '0;
    s[0] = ready;
    s[1] = (cnt >= depth / 4);
    s[2] = (cnt >= depth / 2);
    s[3] = (cnt >= depth);
    for (int b = 0; b < cw; b++) s[4 + b] = ((cnt >> b) & 1) != 0;
    s[4 + cw] = (cnt == 0);
    return s;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int PW    = 6
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_ptr,
  input  logic [7:0]         wr_byte,
  input  logic [PW-1:0]      rd_ptr,
  output logic [8*LANES-1:0] rd_word
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_byte;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PW-1:0] addr;
    assign addr = rd_ptr + PW'(i);
    assign rd_word[8*i +: 8] = mem[addr];
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int CW    = 7,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  input  logic          end_in,
  output logic [CW-1:0] count,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          push_acc,
  output logic [CW-1:0] pop_n,
  output logic          ready
);
  logic          done;
  logic [CW-1:0] count_nx;

  assign push_acc = push_req && (count != CW'(DEPTH)) && !flush;
  assign pop_n    = (pop_req && !flush) ? CW'(take_bytes(32'(count), LANES)) : '0;
  assign count_nx = count + CW'(push_acc) - pop_n;
  assign ready    = (count >= CW'(LANES)) || (done && (count != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      done   <= 1'b0;
    end else if (flush) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      done   <= 1'b0;
    end else begin
      count  <= count_nx;
      wr_ptr <= wr_ptr + PW'(push_acc);
      rd_ptr <= rd_ptr + PW'(pop_n);
      if (end_in)                                done <= 1'b1;
      else if (pop_n != '0 && count_nx == '0)    done <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_regif.sv
module rxq_regif
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int CW    = 7,
  parameter int AW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [8*LANES-1:0] reg_wdata,
  input  logic [8*LANES-1:0] raw_word,
  input  logic [CW-1:0]      count,
  input  logic               ready,
  output logic [8*LANES-1:0] reg_rdata,
  output logic               pop_req,
  output logic               flush,
  output logic               underrun,
  output logic [8*LANES-1:0] stat_word
);
  localparam int DW = 8 * LANES;
  logic [DW-1:0] data_word;

  assign pop_req   = reg_sel && !reg_wr && (reg_addr == AW'(RA_DATA));
  assign flush     = reg_sel &&  reg_wr && (reg_addr == AW'(RA_FLUSH)) && reg_wdata[0];
  assign stat_word = DW'(status_word(32'(count), DEPTH, CW, ready));

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign data_word[8*i +: 8] = (count > CW'(i)) ? raw_word[8*i +: 8] : 8'h00;
  end

  always_comb begin
    case (reg_addr)
      AW'(RA_STAT): reg_rdata = stat_word;
      AW'(RA_DATA): reg_rdata = data_word;
      default:      reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrun <= 1'b0;
    else        underrun <= pop_req && (count == '0);
  end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_byte_vld,
  input  logic [7:0]    rx_byte,
  input  logic          rx_xfer_end,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [2:0]    int_src
);
  localparam int LANES = DW / 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(DEPTH);

  logic [CW-1:0] count;
  logic [CW-1:0] pop_n;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_acc, pop_req, flush, ready, underrun;
  logic [DW-1:0] raw_word, stat_word;

  rxq_level #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW), .PW(PW)) u_level (
    .clk(clk), .rst_n(rst_n), .push_req(rx_byte_vld), .pop_req(pop_req),
    .flush(flush), .end_in(rx_xfer_end), .count(count), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .push_acc(push_acc), .pop_n(pop_n), .ready(ready)
  );

  rxq_store #(.DEPTH(DEPTH), .LANES(LANES), .PW(PW)) u_store (
    .clk(clk), .wr_en(push_acc), .wr_ptr(wr_ptr), .wr_byte(rx_byte),
    .rd_ptr(rd_ptr), .rd_word(raw_word)
  );

  rxq_regif #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW), .AW(AW)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .raw_word(raw_word),
    .count(count), .ready(ready), .reg_rdata(reg_rdata), .pop_req(pop_req),
    .flush(flush), .underrun(underrun), .stat_word(stat_word)
  );

  assign int_src = {ready, count != '0, underrun};
endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          push_acc,
  input logic          pop_req,
  input logic          flush,
  input logic [DW-1:0] stat_word,
  input logic [2:0]    int_src
);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop_req && !flush) |=> (count == CW'(DEPTH)));
  p_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == '0) |=> int_src[0]);
  p_und_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_req && count == '0) |=> !int_src[0]);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_src[1] != stat_word[4 + CW]);
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int_src[2] == stat_word[0]);
  p_pop4_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !flush && !push_acc && count >= CW'(4)) |=> (count == $past(count) - CW'(4)));
  p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !pop_req) |=> (count == $past(count) + CW'(1)));
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .push_acc(push_acc),
  .pop_req(pop_req), .flush(flush), .stat_word(stat_word), .int_src(int_src)
);

// File: tb/sim_rx_word_fifo.sv
module sim_rx_word_fifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_byte_vld = 0;
  logic [7:0]  rx_byte = 0;
  logic        rx_xfer_end = 0;
  logic        reg_sel = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [2:0]  int_src;

  always #4 clk = ~clk;

  rx_word_fifo u0 (.*);

  int errors = 0;
  int checks = 0;
  bit [7:0] q[$];
  bit done_m = 0;
  bit und_m = 0;

  function automatic bit ready_m();
    return (q.size() >= 4) || (done_m && q.size() > 0);
  endfunction

  function automatic bit [31:0] stat_m();
    int n = q.size();
    return ((n == 0) ? 32'h800 : 32'h0) | (n << 4) | ((n >= 64) ? 8 : 0) |
           ((n >= 32) ? 4 : 0) | ((n >= 16) ? 2 : 0) | (ready_m() ? 1 : 0);
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit pv, input bit [7:0] pb, input bit pe, input bit sel,
                      input bit wr, input bit [1:0] a, input bit [31:0] wd, input string tag);
    bit [31:0] exp;
    int sz, n;
    bit fl, rd;
    rx_byte_vld = pv; rx_byte = pb; rx_xfer_end = pe;
    reg_sel = sel; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    exp = 0;
    if (a == 0) exp = stat_m();
    else if (a == 1) for (int i = 0; i < 4; i++) if (i < q.size()) exp[8*i +: 8] = q[i];
    cmp({tag, " rdata"}, reg_rdata, exp);
    cmp({tag, " int_src"}, {29'b0, int_src}, {29'b0, ready_m(), q.size() > 0, und_m});
    @(posedge clk);
    fl = sel && wr && a == 2 && wd[0];
    rd = sel && !wr && a == 1;
    sz = q.size();
    und_m = rd && sz == 0;
    if (fl) begin
      q.delete(); done_m = 0;
    end else begin
      n = rd ? ((sz < 4) ? sz : 4) : 0;
      repeat (n) void'(q.pop_front());
      if (pv && sz < 64) q.push_back(pb);
      if (pe) done_m = 1;
      else if (n > 0 && q.size() == 0) done_m = 0;
    end
    @(negedge clk);
  endtask

  task automatic push(input bit [7:0] b, input string tag); step(1, b, 0, 0, 0, 0, 0, tag); endtask
  task automatic stat(input string tag);  step(0, 0, 0, 1, 0, 0, 0, tag); endtask
  task automatic pop(input string tag);   step(0, 0, 0, 1, 0, 1, 0, tag); endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    stat("R1 reset");
    cmp("R1 reset status", reg_rdata, 32'h800);
    // R2 R3 little-endian packing and count
    for (int i = 0; i < 8; i++) push(8'h11 * (i + 1), "R3 push");
    stat("R3 count8");
    pop("R2 word0"); pop("R2 word1"); stat("R3 drained");
    // R4 thresholds, R10 full drop
    for (int i = 0; i < 16; i++) push(8'(i), "R4 fill");
    stat("R4 at16");
    for (int i = 16; i < 32; i++) push(8'(i), "R4 fill");
    stat("R4 at32");
    for (int i = 32; i < 64; i++) push(8'(i), "R4 fill");
    stat("R4 at64");
    push(8'hEE, "R10 drop");
    stat("R10 still64");
    step(1, 8'hDD, 0, 1, 0, 1, 0, "R10 push with pop at full");
    stat("R10 after");
    for (int i = 0; i < 16; i++) pop("R10 drain contents");
    stat("R7 empty");
    // R5 R6 partial with end
    push(8'hA1, "R5"); push(8'hA2, "R5"); push(8'hA3, "R5");
    stat("R5 not ready");
    step(0, 0, 1, 0, 0, 0, 0, "R5 end");
    stat("R5 ready after end");
    pop("R6 partial");
    push(8'hB1, "R6"); push(8'hB2, "R6");
    stat("R6 end cleared");
    pop("R6 partial no end");
    // R8 underrun
    pop("R8 empty read");
    stat("R8 pulse");
    stat("R8 one cycle");
    // R9 flush
    for (int i = 0; i < 10; i++) push(8'(8'h40 + i), "R9 fill");
    step(0, 0, 0, 1, 1, 2, 0, "R9 write zero");
    stat("R9 unchanged");
    step(1, 8'h77, 1, 1, 1, 2, 1, "R9 flush");
    stat("R9 empty");
    push(8'h01, "R9 no end kept"); stat("R9 not ready");
    pop("R9 drain");
    // R12 concurrent push and pop
    for (int i = 0; i < 5; i++) push(8'(8'h60 + i), "R12 fill");
    for (int i = 0; i < 6; i++) step(1, 8'(8'h70 + i), 0, 1, 0, 1, 0, "R12 push+pop");
    // mixed random run
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit pv = $urandom_range(0, 2) != 0;
      bit pe = $urandom_range(0, 30) == 0;
      if (r < 45)      step(pv, 8'($urandom), pe, 0, 0, 0, 0, "R12 rand");
      else if (r < 80) step(pv, 8'($urandom), pe, 1, 0, 1, 0, "R12 rand pop");
      else if (r < 98) step(pv, 8'($urandom), pe, 1, 0, 0, 0, "R4 rand stat");
      else             step(pv, 8'($urandom), pe, 1, 1, 2, 32'($urandom_range(0, 1)), "R9 rand");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule